// File: doc/BRIEF.md
# I2C Configuration Slave

This block connects a standard-mode I2C master to a twelve-byte configuration register bank. It oversamples SCL and SDA with the system clock and recognises START and STOP conditions. It compares the first byte of each transfer against its own 7-bit device address and shifts data most significant bit first. It drives SDA only through an open-drain output enable.

No byte offset is carried on the bus. In a write, the byte that follows the address is taken as filler: it is acknowledged and then thrown away. The bytes after it fill the bank from index 0 upward. A read returns the bank from index 0 upward, and the master ends it with a no-acknowledge. Each new transaction starts again at index 0. The bank itself lives outside the block. The block reaches it through one single-cycle write strobe and one combinational read port.

Top module: `cfg_i2c_slave`

## Requirements
- R1: While `rst_n` is low and afterwards until a matching address arrives, `sda_oe` stays 0 and `reg_wr_en` stays 0.
- R2: The device address, MSB to LSB, is 1,1,`strap_addr[2]`,0,0,`strap_addr[1]`,`strap_addr[0]`. The eighth bit of the first byte selects the direction: 1 reads and 0 writes. On a mismatch the slave leaves SDA released for the whole transfer and writes nothing.
- R3: START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. After a STOP the next transfer starts at bank index 0.
- R4: The slave pulls SDA low for the whole high phase of the acknowledge clock after a matching address and after every byte it receives in a write.
- R5: In a write, the first byte after the address is acknowledged and discarded. Each later byte produces exactly one single-cycle `reg_wr_en` pulse. The pulses go to index 0, 1, 2 in turn, and the data bits are assembled MSB first.
- R6: In a read, bytes come out MSB first from index 0 upward. A master acknowledge moves on to the next byte. A master no-acknowledge makes the slave release SDA and stop sending.
- R7: A write byte aimed past index 11 is still acknowledged, but it causes no `reg_wr_en`. A read past index 11 returns 0x00.
- R8: A repeated START in the middle of a transfer abandons it. Address matching begins again and the index returns to 0.
- R9: The block has no SCL driver and never stretches the clock. SDA is only ever pulled low, never driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| strap_addr | input | 3 | Programmable address bits {A4, A1, A0} |
| reg_wr_en | output | 1 | One-cycle write strobe to the bank |
| reg_wr_idx | output | IDXW | Bank index for the write |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_idx | output | IDXW | Bank index being read |
| reg_rd_data | input | 8 | Bank byte at `reg_rd_idx` |

## Verification
The assertions run on every cycle and check four rules. SDA stays stable while SCL remains high, except at START or STOP. The slave is quiet while idle. SDA is held low through each acknowledge state. Write strobes are single pulses aimed only inside the bank. The remaining behaviour can only be shown by the bench's bus scenarios. These cover address matching against the strap pins and the discarded filler byte. They also cover sequential indexing from zero, the out-of-range write and read rules, the master no-acknowledge, and the repeated-START restart.

// File: rtl/i2cs_pkg.sv
// Shared types for the I2C configuration slave.
// Assumes: nothing beyond IEEE 1800-2017.
package i2cs_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } i2cs_state_t;

    // Fixed bits of the 7-bit device address
    localparam logic [1:0] ADDR_HI  = 2'b11;
    localparam logic [1:0] ADDR_MID = 2'b00;

endpackage

// File: rtl/i2cs_line_sync.sv
// Bus line conditioner. It brings SCL and SDA into the clock domain
// through STAGES flops plus one more sample stage. It then reports the
// SCL edges and the START/STOP conditions.
// Assumes: the bus is idle-high and the clock is much faster than SCL.
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int TOP = STAGES;

    logic [TOP:0] scl_sh;
    logic [TOP:0] sda_sh;
    logic         scl_prev;
    logic         sda_prev;

    // Shift both lines through the synchronizer and the extra sample stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
        end else begin
            scl_sh <= {scl_sh[TOP-1:0], scl_i};
            sda_sh <= {sda_sh[TOP-1:0], sda_i};
        end
    end

    assign scl_lvl  = scl_sh[TOP-1];
    assign sda_lvl  = sda_sh[TOP-1];
    assign scl_prev = scl_sh[TOP];
    assign sda_prev = sda_sh[TOP];

    assign scl_rise  = scl_lvl & ~scl_prev;
    assign scl_fall  = ~scl_lvl & scl_prev;
    assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2cs_engine.sv
// Protocol engine. It matches the address, receives bytes, sends bytes
// and generates acknowledges. It keeps a sequential bank index that
// starts at 0 for every transaction.
// Assumes: edge and condition strobes come from i2cs_line_sync, and
// rd_data is a combinational function of rd_idx.
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter int NREG = 12,
    parameter int IDXW = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_lvl,
    input  logic            sda_lvl,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_det,
    input  logic            stop_det,
    input  logic [6:0]      dev_addr,
    input  logic [7:0]      rd_data,
    output logic            sda_oe,
    output logic            wr_en,
    output logic [IDXW-1:0] wr_idx,
    output logic [7:0]      wr_data,
    output logic [IDXW-1:0] rd_idx
);

    localparam logic [IDXW-1:0] LIMIT = IDXW'(NREG);
    localparam logic [IDXW-1:0] TOPIX = '1;

    i2cs_state_t     st;
    logic [7:0]      sh;
    logic [7:0]      tx;
    logic [2:0]      cnt;
    logic            got;
    logic            rnw;
    logic            first;
    logic            mack;
    logic [IDXW-1:0] ptr;
    logic [IDXW-1:0] ptr_inc;
    logic [7:0]      tx_byte;

    // Saturating index step, so that indices past the bank stay past it
    assign ptr_inc = (ptr == TOPIX) ? ptr : ptr + 1'b1;
    // Bytes past the bank read as zero
    assign tx_byte = (ptr < LIMIT) ? rd_data : 8'h00;
    assign rd_idx  = ptr;

    // Main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            sh      <= '0;
            tx      <= '0;
            cnt     <= '0;
            got     <= 1'b0;
            rnw     <= 1'b0;
            first   <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                got    <= 1'b0;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st     <= ST_IDLE;
                ptr    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WR: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_lvl};
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) got <= 1'b1;
                        end else if (scl_fall && got) begin
                            got <= 1'b0;
                            if (st == ST_ADDR) begin
                                if (sh[7:1] == dev_addr) begin
                                    st     <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                    rnw    <= sh[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                st     <= ST_WR_ACK;
                                sda_oe <= 1'b1;
                                first  <= 1'b0;
                                if (!first) begin
                                    wr_en   <= (ptr < LIMIT);
                                    wr_idx  <= ptr;
                                    wr_data <= sh;
                                    ptr     <= ptr_inc;
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rnw) begin
                                st     <= ST_RD;
                                tx     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                st     <= ST_WR;
                                first  <= 1'b1;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            st     <= ST_WR;
                            sda_oe <= 1'b0;
                        end
                    end
                    ST_RD: begin
                        if (scl_fall) begin
                            if (cnt == 3'd7) begin
                                st     <= ST_RD_ACK;
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                            end else begin
                                sda_oe <= ~tx[6];
                                tx     <= {tx[6:0], 1'b0};
                                cnt    <= cnt + 3'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                            if (!sda_lvl) ptr <= ptr_inc;
                        end else if (scl_fall) begin
                            if (mack) begin
                                st     <= ST_RD;
                                tx     <= tx_byte;
                                sda_oe <= ~tx_byte[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // SDA may only change while SCL is low, or at a START/STOP (R4)
    p_sda_stable_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !$past(start_det) && !$past(stop_det))
        |-> $stable(sda_oe));

    // Acknowledge states hold SDA low (R4)
    p_ack_drives_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR_ACK || st == ST_WR_ACK) |-> sda_oe);

    // Idle slave leaves the bus alone (R1)
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // Write strobes stay inside the bank (R7)
    p_wr_in_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < LIMIT));

    // One strobe per received byte (R5)
    p_wr_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

// File: rtl/cfg_i2c_slave.sv
// I2C configuration slave top. It builds the device address from the
// strap pins and joins the line conditioner to the protocol engine.
// Assumes: the external bank answers reg_rd_idx combinationally and
// stores a byte on each reg_wr_en pulse.
module cfg_i2c_slave
    import i2cs_pkg::*;
#(
    parameter int NREG      = 12,
    parameter int SYNC_FLOP = 2,
    parameter int IDXW      = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe,
    input  logic [2:0]      strap_addr,
    output logic            reg_wr_en,
    output logic [IDXW-1:0] reg_wr_idx,
    output logic [7:0]      reg_wr_data,
    output logic [IDXW-1:0] reg_rd_idx,
    input  logic [7:0]      reg_rd_data
);

    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0] dev_addr;

    // Device address: fixed high pair, strap A4, fixed zero pair, straps A1 A0
    assign dev_addr = {ADDR_HI, strap_addr[2], ADDR_MID, strap_addr[1:0]};

    i2cs_line_sync #(.STAGES(SYNC_FLOP)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_engine #(.NREG(NREG), .IDXW(IDXW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (reg_wr_en),
        .wr_idx    (reg_wr_idx),
        .wr_data   (reg_wr_data),
        .rd_idx    (reg_rd_idx)
    );

endmodule

// File: tb/sim_cfg_i2c_slave.sv
module sim_cfg_i2c_slave;

    localparam int NREG = 12;
    localparam int IDXW = 4;
    localparam int Q    = 16;   // clocks per quarter SCL period

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            m_scl = 1'b1;
    logic            m_low = 1'b0;
    logic [2:0]      strap = 3'b000;
    logic            sda_oe;
    logic            reg_wr_en;
    logic [IDXW-1:0] reg_wr_idx;
    logic [7:0]      reg_wr_data;
    logic [IDXW-1:0] reg_rd_idx;
    logic [7:0]      reg_rd_data;
    logic            sda_line;
    logic            clr_req = 1'b0;
    logic [7:0]      mem [0:NREG-1];
    int              wr_count = 0;
    int              checks = 0;
    int              errors = 0;
    bit              done = 1'b0;

    always #5 clk = ~clk;

    assign sda_line    = ~(m_low | sda_oe);
    assign reg_rd_data = (reg_rd_idx < NREG) ? mem[reg_rd_idx] : 8'hEE;

    cfg_i2c_slave #(.NREG(NREG)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .strap_addr  (strap),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_idx  (reg_wr_idx),
        .reg_wr_data (reg_wr_data),
        .reg_rd_idx  (reg_rd_idx),
        .reg_rd_data (reg_rd_data)
    );

    // Behavioural register bank
    always @(posedge clk) begin
        if (clr_req) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'hFF;
        end else if (reg_wr_en) begin
            wr_count <= wr_count + 1;
            if (reg_wr_idx < NREG) mem[reg_wr_idx] <= reg_wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_bank();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b1; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_low = 1'b0; wq(Q);
    endtask

    // Send a byte; ack is 1 only if SDA was low at three points of the high phase
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a0, a1, a2;
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(Q);
            m_scl = 1'b1;  wq(2*Q);
            m_scl = 1'b0;  wq(Q);
        end
        m_low = 1'b0; wq(Q);
        m_scl = 1'b1; wq(1);
        a0 = ~sda_line; wq(Q);
        a1 = ~sda_line; wq(Q - 2);
        a2 = ~sda_line; wq(1);
        m_scl = 1'b0; wq(Q);
        ack = a0 & a1 & a2;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            wq(Q);
            m_scl = 1'b1; wq(Q);
            d = {d[6:0], sda_line}; wq(Q);
            m_scl = 1'b0; wq(Q);
        end
        m_low = mack; wq(Q);
        m_scl = 1'b1; wq(2*Q);
        m_scl = 1'b0; wq(Q);
        m_low = 1'b0;
    endtask

    // Stimulus table: strap, address sent, data0, data1, expected ack
    localparam logic [26:0] VEC [0:5] = '{
        {3'b000, 7'h60, 8'h11, 8'h22, 1'b1},
        {3'b101, 7'h71, 8'hA7, 8'h5C, 1'b1},
        {3'b011, 7'h63, 8'h80, 8'h01, 1'b1},
        {3'b111, 7'h73, 8'hF0, 8'h0F, 1'b1},
        {3'b000, 7'h61, 8'h33, 8'h44, 1'b0},
        {3'b010, 7'h60, 8'h55, 8'h66, 1'b0}
    };

    initial begin
        bit          ack, all_ack;
        logic [7:0]  d;
        int          base;

        for (int i = 0; i < NREG; i++) mem[i] = 8'hFF;
        wq(5);
        // R1: reset state
        chk(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        chk(reg_wr_en == 1'b0, "R1 wr_en in reset", reg_wr_en, 0);
        rst_n = 1'b1; wq(5);
        chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

        // Table walk: address matching (R2), ack (R4), filler byte and ordering (R5)
        foreach (VEC[k]) begin
            strap = VEC[k][26:24];
            clear_bank();
            base = wr_count;
            i2c_start();
            send_byte({VEC[k][23:17], 1'b0}, ack);
            chk(ack == VEC[k][0], "R2 address ack", ack, VEC[k][0]);
            if (VEC[k][0]) begin
                all_ack = 1'b1;
                send_byte(8'hA5, ack); all_ack &= ack;
                send_byte(VEC[k][16:9], ack); all_ack &= ack;
                send_byte(VEC[k][8:1], ack); all_ack &= ack;
                chk(all_ack, "R4 data acks", all_ack, 1);
            end else begin
                send_byte(8'hA5, ack);
                chk(!ack, "R2 no ack after mismatch", ack, 0);
            end
            i2c_stop(); wq(4);
            if (VEC[k][0]) begin
                chk(mem[0] == VEC[k][16:9], "R5 byte to index 0", mem[0], VEC[k][16:9]);
                chk(mem[1] == VEC[k][8:1], "R5 byte to index 1", mem[1], VEC[k][8:1]);
                chk(mem[2] == 8'hFF, "R5 filler discarded", mem[2], 8'hFF);
                chk(wr_count - base == 2, "R5 strobe count", wr_count - base, 2);
            end else begin
                chk(wr_count == base, "R2 mismatch writes nothing", wr_count - base, 0);
            end
        end

        // R7: write past the bank
        strap = 3'b000;
        clear_bank();
        base = wr_count;
        all_ack = 1'b1;
        i2c_start();
        send_byte(8'hC0, ack); all_ack &= ack;
        send_byte(8'h00, ack); all_ack &= ack;
        for (int i = 0; i < 14; i++) begin
            send_byte(8'h30 + 8'(i), ack); all_ack &= ack;
        end
        i2c_stop(); wq(4);
        chk(all_ack, "R7 all bytes acked", all_ack, 1);
        chk(wr_count - base == NREG, "R7 strobes only inside bank", wr_count - base, NREG);
        for (int i = 0; i < NREG; i++)
            chk(mem[i] == 8'h30 + 8'(i), "R5 sequential store", mem[i], 8'h30 + i);

        // R6 / R7: read 14 bytes from index 0
        i2c_start();
        send_byte(8'hC1, ack);
        chk(ack, "R2 read address ack", ack, 1);
        for (int i = 0; i < 14; i++) begin
            recv_byte(i != 13, d);
            if (i < NREG) chk(d == 8'h30 + 8'(i), "R6 read sequence", d, 8'h30 + i);
            else          chk(d == 8'h00, "R7 read past bank", d, 0);
        end
        wq(2);
        chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        i2c_stop(); wq(4);

        // R3: next transaction restarts at index 0
        i2c_start();
        send_byte(8'hC1, ack);
        recv_byte(1'b1, d);
        chk(d == 8'h30, "R3 restart at index 0", d, 8'h30);
        recv_byte(1'b0, d);
        chk(d == 8'h31, "R3 second byte", d, 8'h31);
        i2c_stop(); wq(4);

        // R8: repeated START abandons the write and restarts at index 0
        i2c_start();
        send_byte(8'hC0, ack);
        send_byte(8'h00, ack);
        send_byte(8'h5A, ack);
        send_byte(8'h6B, ack);
        i2c_start();
        send_byte(8'hC0, ack);
        chk(ack, "R8 address after repeated START", ack, 1);
        send_byte(8'h00, ack);
        send_byte(8'hC3, ack);
        i2c_stop(); wq(4);
        chk(mem[0] == 8'hC3, "R8 index back to 0", mem[0], 8'hC3);
        chk(mem[1] == 8'h6B, "R8 later byte untouched", mem[1], 8'h6B);

        // R8: repeated START from write into read
        i2c_start();
        send_byte(8'hC0, ack);
        send_byte(8'h00, ack);
        i2c_start();
        send_byte(8'hC1, ack);
        recv_byte(1'b0, d);
        chk(d == 8'hC3, "R8 read after repeated START", d, 8'hC3);
        i2c_stop(); wq(4);

        // R2: mismatched read address leaves SDA released
        i2c_start();
        send_byte(8'hD3, ack);
        chk(!ack, "R2 read mismatch nack", ack, 0);
        recv_byte(1'b0, d);
        chk(d == 8'hFF, "R2 slave silent on mismatch", d, 8'hFF);
        i2c_stop(); wq(4);
        chk(sda_oe == 1'b0, "R9 bus released at end", sda_oe, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule